// File: doc/BRIEF.md
# FIFO-Backed Register File Read Path

This block is a small control and status register file on a plain local bus. The bus carries an address, a write strobe, a read request, 64-bit write data, 64-bit read data and a read-valid flag. Four registers are decoded: a read-only identification word, a data port, a status word and a 64-bit control word. The data port is backed by two queues. A bus write to it pushes a word into a transmit queue, which an external consumer drains. A bus read from it pops a word from a receive queue, which an external producer fills.

The receive queue can be built in one of two forms, chosen by `RD_LATENCY`. With 0, its head word is visible with no delay. With 1, the word appears on a registered output one cycle after the pop. In both forms the response path makes the read-valid pulse and the returned word belong to the same pop. Only the logic for the chosen form is elaborated.

A bus master raises `bus_ren` with an address and holds it until it sees `bus_rvalid`. A write is a single-cycle `bus_wen` strobe.

Top module: `csr_fifo_regs`

## Requirements
- R1: Decode uses byte addresses: identification at 0x00, data port at 0x08, status at 0x10 and control at 0x18. Any other address reads as zero, and a write to it changes nothing.
- R2: For a non-data register, a read is accepted when `bus_ren` is 1 and `bus_rvalid` is 0. `bus_rvalid` is then high for exactly one cycle, on the next cycle, with the data. If `bus_ren` stays high, a new read is accepted every second cycle.
- R3: `bus_rdata` is zero in every cycle in which `bus_rvalid` is low.
- R4: The control register is 64 bits wide, resets to 0, is readable and writable, and drives `ctrl_out`. The identification register reads `ID_VALUE`, and writes to it are ignored.
- R5: A write to the data port pushes `bus_wdata[31:0]` into the transmit queue. The transmit side shows its oldest word on `tx_data` with `tx_valid` high. `tx_pop` removes that word, and words leave in the order they were written.
- R6: A read of the data port pops one receive word and returns it in `bus_rdata[31:0]`, with bits 63:32 zero. `bus_rvalid` rises exactly one cycle after the pop. Words come back in push order, and the timing is the same for `RD_LATENCY` 0 and 1.
- R7: Each accepted data-port read pops exactly one word, even while `bus_ren` stays high across the response.
- R8: While the receive queue is empty, a pending data-port read neither pops nor raises `bus_rvalid`. It completes once a word arrives.
- R9: A data-port write while the transmit queue is full is dropped and sets status bit 0. That bit stays set until the bus writes 1 to bit 0 of the status register. Writing 0 to that bit leaves it unchanged.
- R10: Status bit 1 reads 1 when the receive queue holds a word. Status bit 2 reads 1 when the transmit queue is full. All other status bits read 0.
- R11: `rx_push` while the receive queue is full is dropped, and `rx_full` signals that state.
- R12: Synchronous reset clears `bus_rvalid`, `bus_rdata`, the control register, status bit 0 and both queues.
- R13: `RD_LATENCY` values other than 0 and 1, queue depths below 2, and a field wider than the bus are rejected at elaboration.

Parameter defaults: `ADDR_W` 8, `DATA_W` 64, `FIELD_W` 32, `RX_DEPTH` 4, `TX_DEPTH` 4, `RD_LATENCY` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read request, held until `bus_rvalid` |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read response valid |
| rx_push | input | 1 | Push into receive queue |
| rx_push_data | input | FIELD_W | Word to push |
| rx_full | output | 1 | Receive queue full |
| tx_pop | input | 1 | Pop from transmit queue |
| tx_data | output | FIELD_W | Transmit head word |
| tx_valid | output | 1 | Transmit queue not empty |
| ctrl_out | output | DATA_W | Control register contents |

## Verification
The bench runs two copies of the block side by side, one per receive-queue latency, on the same stimulus. It requires both copies to return the same words in the same cycle. A zero-latency path that captured data a cycle off would return the following word or a stale one, and the push-order check would catch it. Holding `bus_ren` high across a response exposes a design that pops twice per read: the status read afterwards would show the queue drained too early. A read pending on an empty queue must stay silent until a word arrives, where a faulty design would return garbage or pop nothing. Overflow on both queues is also exercised, along with the write-one-to-clear status bit and a mid-run reset, so a lost drop, a status bit that clears when 0 is written, or state that survives reset all show up as wrong read values.

// File: rtl/csr_fifo_pkg.sv
package csr_fifo_pkg;

   localparam int unsigned OFS_ID   = 0;
   localparam int unsigned OFS_DATA = 8;
   localparam int unsigned OFS_STAT = 16;
   localparam int unsigned OFS_CTRL = 24;

   localparam int STAT_OVF_BIT    = 0;
   localparam int STAT_RXAV_BIT   = 1;
   localparam int STAT_TXFULL_BIT = 2;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ID,
      SEL_DATA,
      SEL_STAT,
      SEL_CTRL
   } csr_sel_e;

endpackage

// File: rtl/csr_queue.sv
module csr_queue #(
   parameter int WIDTH   = 32,
   parameter int DEPTH   = 4,
   parameter int LATENCY = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             not_empty,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign not_empty = (count != '0);
   assign full      = (count == CNT_W'(DEPTH));
   assign do_push   = push && !full;
   assign do_pop    = pop && not_empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   generate
      if (LATENCY == 0) begin : g_fall_through
         assign head = mem[rd_ptr];
      end else begin : g_registered
         logic [WIDTH-1:0] head_q;
         always_ff @(posedge clk) begin
            if (rst)         head_q <= '0;
            else if (do_pop) head_q <= mem[rd_ptr];
         end
         assign head = head_q;
      end
   endgenerate

endmodule

// File: rtl/csr_rx_path.sv
module csr_rx_path #(
   parameter int WIDTH      = 32,
   parameter int RD_LATENCY = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pop,
   input  logic [WIDTH-1:0] queue_head,
   output logic             resp_valid,
   output logic [WIDTH-1:0] resp_data
);
   logic valid_q;

   // The response always lands one cycle after the pop.
   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= pop;
   end
   assign resp_valid = valid_q;

   generate
      if (RD_LATENCY == 0) begin : g_lat0
         // Head is live during the pop cycle: capture it there.
         logic [WIDTH-1:0] cap_q;
         always_ff @(posedge clk) begin
            if (rst)      cap_q <= '0;
            else if (pop) cap_q <= queue_head;
         end
         assign resp_data = cap_q;
      end else begin : g_lat1
         // Queue registers the popped word itself; use it as it appears.
         assign resp_data = queue_head;
      end
   endgenerate

endmodule

// File: rtl/csr_fifo_regs.sv
module csr_fifo_regs
   import csr_fifo_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 64,
   parameter int                FIELD_W    = 32,
   parameter int                RX_DEPTH   = 4,
   parameter int                TX_DEPTH   = 4,
   parameter int                RD_LATENCY = 0,
   parameter logic [DATA_W-1:0] ID_VALUE   = DATA_W'(64'h0000_C5F0_0001_0002)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wen,
   input  logic               bus_ren,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_rvalid,
   input  logic               rx_push,
   input  logic [FIELD_W-1:0] rx_push_data,
   output logic               rx_full,
   input  logic               tx_pop,
   output logic [FIELD_W-1:0] tx_data,
   output logic               tx_valid,
   output logic [DATA_W-1:0]  ctrl_out
);
   // Elaboration checks (R13)
   generate
      if (RD_LATENCY != 0 && RD_LATENCY != 1) begin : g_bad_latency
         $error("RD_LATENCY must be 0 or 1");
      end
      if (RX_DEPTH < 2 || TX_DEPTH < 2) begin : g_bad_depth
         $error("queue depths must be at least 2");
      end
      if (FIELD_W > DATA_W) begin : g_bad_field
         $error("FIELD_W must not exceed DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   csr_sel_e           sel;
   logic               rd_is_data;
   logic               reg_acc, rx_pop;
   logic               reg_valid_q;
   logic [DATA_W-1:0]  reg_rdata_q, rd_mux, stat_word;
   logic [DATA_W-1:0]  ctrl_q;
   logic               ovf_q, ovf_set, ovf_clr;
   logic               tx_push, tx_full;
   logic               rx_avail;
   logic [FIELD_W-1:0] rx_head;
   logic               dp_valid;
   logic [FIELD_W-1:0] dp_data;
   logic               wdata_unused;

   assign wdata_unused = ^bus_wdata;

   // Address decode (R1)
   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_ID))   sel = SEL_ID;
      else if (bus_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
      else if (bus_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
      else                                    sel = SEL_NONE;
   end

   // Write side
   assign tx_push = bus_wen && (sel == SEL_DATA);
   assign ovf_set = tx_push && tx_full;
   assign ovf_clr = bus_wen && (sel == SEL_STAT) && bus_wdata[STAT_OVF_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (bus_wen && sel == SEL_CTRL) ctrl_q <= bus_wdata;
         if (ovf_set)      ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
      end
   end
   assign ctrl_out = ctrl_q;

   csr_queue #(.WIDTH(FIELD_W), .DEPTH(TX_DEPTH), .LATENCY(0)) u_tx_queue (
      .clk       (clk),
      .rst       (rst),
      .push      (tx_push),
      .push_data (bus_wdata[FIELD_W-1:0]),
      .pop       (tx_pop),
      .head      (tx_data),
      .not_empty (tx_valid),
      .full      (tx_full)
   );

   // Read side
   assign rd_is_data = (sel == SEL_DATA);
   assign reg_acc    = bus_ren && !bus_rvalid && !rd_is_data;
   assign rx_pop     = bus_ren && !bus_rvalid && rd_is_data && rx_avail;

   always_comb begin
      stat_word                  = '0;
      stat_word[STAT_OVF_BIT]    = ovf_q;
      stat_word[STAT_RXAV_BIT]   = rx_avail;
      stat_word[STAT_TXFULL_BIT] = tx_full;
   end

   always_comb begin
      unique case (sel)
         SEL_ID:   rd_mux = ID_VALUE;
         SEL_STAT: rd_mux = stat_word;
         SEL_CTRL: rd_mux = ctrl_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_valid_q <= 1'b0;
         reg_rdata_q <= '0;
      end else begin
         reg_valid_q <= reg_acc;
         reg_rdata_q <= reg_acc ? rd_mux : '0;
      end
   end

   csr_queue #(.WIDTH(FIELD_W), .DEPTH(RX_DEPTH), .LATENCY(RD_LATENCY)) u_rx_queue (
      .clk       (clk),
      .rst       (rst),
      .push      (rx_push),
      .push_data (rx_push_data),
      .pop       (rx_pop),
      .head      (rx_head),
      .not_empty (rx_avail),
      .full      (rx_full)
   );

   csr_rx_path #(.WIDTH(FIELD_W), .RD_LATENCY(RD_LATENCY)) u_rx_path (
      .clk        (clk),
      .rst        (rst),
      .pop        (rx_pop),
      .queue_head (rx_head),
      .resp_valid (dp_valid),
      .resp_data  (dp_data)
   );

   assign bus_rvalid = reg_valid_q || dp_valid;
   assign bus_rdata  = reg_valid_q ? reg_rdata_q :
                       dp_valid    ? DATA_W'(dp_data) : '0;

endmodule

// File: rtl/csr_fifo_regs_chk.sv
module csr_fifo_regs_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_ren,
   input logic              bus_rvalid,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              rd_is_data,
   input logic              reg_acc,
   input logic              rx_pop,
   input logic              rx_avail,
   input logic              ovf_q,
   input logic              ovf_clr
);
   assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      bus_rvalid |=> !bus_rvalid);

   assert_reg_response_R2: assert property (@(posedge clk) disable iff (rst)
      reg_acc |=> bus_rvalid);

   assert_rdata_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !bus_rvalid |-> (bus_rdata == '0));

   assert_pop_response_R6: assert property (@(posedge clk) disable iff (rst)
      rx_pop |=> bus_rvalid);

   assert_single_pop_R7: assert property (@(posedge clk) disable iff (rst)
      rx_pop |=> !rx_pop);

   assert_empty_wait_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_ren && !bus_rvalid && rd_is_data && !rx_avail) |=> !bus_rvalid);

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (ovf_q && !ovf_clr) |=> ovf_q);

endmodule

bind csr_fifo_regs csr_fifo_regs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_ren    (bus_ren),
   .bus_rvalid (bus_rvalid),
   .bus_rdata  (bus_rdata),
   .rd_is_data (rd_is_data),
   .reg_acc    (reg_acc),
   .rx_pop     (rx_pop),
   .rx_avail   (rx_avail),
   .ovf_q      (ovf_q),
   .ovf_clr    (ovf_clr)
);

// File: tb/csr_fifo_regs_bench.sv
`timescale 1ns/1ps
module csr_fifo_regs_bench;
   localparam logic [63:0] ID_V = 64'h1D00_0000_CAFE_0042;
   localparam logic [7:0] A_ID = 8'h00, A_DATA = 8'h08, A_STAT = 8'h10, A_CTRL = 8'h18;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [63:0] data;
      logic [63:0] exp;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, A_CTRL, 64'hDEADBEEF_12345678, 64'h0},
      '{1'b0, A_CTRL, 64'h0, 64'hDEADBEEF_12345678},
      '{1'b0, A_ID,   64'h0, ID_V},
      '{1'b1, A_ID,   64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
      '{1'b0, A_ID,   64'h0, ID_V},
      '{1'b0, 8'h20,  64'h0, 64'h0},
      '{1'b1, 8'h28,  64'h55, 64'h0},
      '{1'b0, A_CTRL, 64'h0, 64'hDEADBEEF_12345678},
      '{1'b0, A_STAT, 64'h0, 64'h0},
      '{1'b0, 8'h0C,  64'h0, 64'h0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic        bus_wen = 1'b0, bus_ren = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic        rx_push = 1'b0, tx_pop = 1'b0;
   logic [31:0] rx_push_data = '0;
   logic [63:0] rd0, rd1, ctrl0, ctrl1;
   logic        rv0, rv1, rxf0, rxf1, txv0, txv1;
   logic [31:0] txd0, txd1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   csr_fifo_regs #(.RD_LATENCY(0), .ID_VALUE(ID_V)) u_csr_fifo_regs (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
      .bus_wdata(bus_wdata), .bus_rdata(rd0), .bus_rvalid(rv0),
      .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_full(rxf0),
      .tx_pop(tx_pop), .tx_data(txd0), .tx_valid(txv0), .ctrl_out(ctrl0));

   csr_fifo_regs #(.RD_LATENCY(1), .ID_VALUE(ID_V)) u_csr_fifo_regs_lat1 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
      .bus_wdata(bus_wdata), .bus_rdata(rd1), .bus_rvalid(rv1),
      .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_full(rxf1),
      .tx_pop(tx_pop), .tx_data(txd1), .tx_valid(txv1), .ctrl_out(ctrl1));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [63:0] d0,
                           output logic [63:0] d1, output int lat);
      @(negedge clk);
      bus_addr = a; bus_ren = 1'b1; lat = 0; d0 = '0; d1 = '0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         lat++;
         if (rv0 || rv1) begin
            chk("R6 both latency modes respond in the same cycle", {63'b0, rv1}, {63'b0, rv0});
            d0 = rd0; d1 = rd1;
            break;
         end
      end
      bus_ren = 1'b0;
   endtask

   task automatic rx_put(input logic [31:0] w);
      @(negedge clk);
      rx_push = 1'b1; rx_push_data = w;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic read_expect(input string req, input logic [7:0] a, input logic [63:0] e);
      logic [63:0] d0, d1;
      int lat;
      bus_read(a, d0, d1, lat);
      chk({req, " lat0"}, d0, e);
      chk({req, " lat1"}, d1, e);
      chk({req, " latency"}, 64'(lat), 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12 reset state
      chk("R12 rvalid after reset", {62'b0, rv1, rv0}, 64'd0);
      chk("R12 rdata after reset", rd0 | rd1, 64'd0);
      chk("R12 ctrl after reset", ctrl0 | ctrl1, 64'd0);
      chk("R12 queues empty after reset", {60'b0, txv1, txv0, rxf1, rxf0}, 64'd0);
      read_expect("R12 ctrl read after reset", A_CTRL, 64'd0);

      // Table walk: R1 R2 R4 R10
      for (int k = 0; k < NVEC; k++) begin
         if (VECS[k].wr) bus_write(VECS[k].addr, VECS[k].data);
         else read_expect($sformatf("R1/R4 vector %0d", k), VECS[k].addr, VECS[k].exp);
      end
      chk("R4 ctrl_out", ctrl0, 64'hDEADBEEF_12345678);

      // R2 held read of a plain register: response every second cycle
      @(negedge clk);
      bus_addr = A_CTRL; bus_ren = 1'b1;
      @(negedge clk); chk("R2 held read first response", {63'b0, rv0}, 64'd1);
      @(negedge clk); chk("R2 held read gap", {63'b0, rv0}, 64'd0);
      chk("R3 rdata zero in gap", rd0, 64'd0);
      @(negedge clk); chk("R2 held read second response", {63'b0, rv0}, 64'd1);
      bus_ren = 1'b0;

      // R6 order of receive words, both modes
      rx_put(32'hA0A0_0001); rx_put(32'hB0B0_0002); rx_put(32'hC0C0_0003);
      read_expect("R10 status rx available", A_STAT, 64'h2);
      read_expect("R6 first word", A_DATA, 64'hA0A0_0001);
      read_expect("R6 second word", A_DATA, 64'hB0B0_0002);
      read_expect("R6 third word", A_DATA, 64'hC0C0_0003);
      read_expect("R10 status rx empty", A_STAT, 64'h0);

      // R7 held data read pops one word per accepted read
      rx_put(32'hD1); rx_put(32'hE2); rx_put(32'hF3);
      @(negedge clk);
      bus_addr = A_DATA; bus_ren = 1'b1;
      @(negedge clk);
      chk("R7 held data read 1 lat0", rv0 ? rd0 : 64'hX, 64'hD1);
      chk("R7 held data read 1 lat1", rv1 ? rd1 : 64'hX, 64'hD1);
      @(negedge clk);
      chk("R7 no response during gap", {62'b0, rv1, rv0}, 64'd0);
      @(negedge clk);
      chk("R7 held data read 2 lat0", rv0 ? rd0 : 64'hX, 64'hE2);
      chk("R7 held data read 2 lat1", rv1 ? rd1 : 64'hX, 64'hE2);
      bus_ren = 1'b0;
      read_expect("R7 one word still queued", A_STAT, 64'h2);
      read_expect("R7 remaining word", A_DATA, 64'hF3);

      // R8 read pending on an empty queue
      @(negedge clk);
      bus_addr = A_DATA; bus_ren = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R8 no response while empty", {62'b0, rv1, rv0}, 64'd0);
      end
      rx_push = 1'b1; rx_push_data = 32'h6060_6060;
      @(negedge clk);
      rx_push = 1'b0;
      for (int i = 0; i < 10; i++) begin
         if (rv0 || rv1) break;
         @(negedge clk);
      end
      chk("R8 late word lat0", rv0 ? rd0 : 64'hX, 64'h6060_6060);
      chk("R8 late word lat1", rv1 ? rd1 : 64'hX, 64'h6060_6060);
      bus_ren = 1'b0;

      // R5 / R9 transmit queue and overflow flag
      for (int i = 0; i < 4; i++) bus_write(A_DATA, 64'hFFFF_0000_0000_0100 + 64'(i));
      chk("R5 tx head", {31'b0, txv0, txd0}, {31'b0, 1'b1, 32'h0000_0100});
      read_expect("R10 status tx full", A_STAT, 64'h4);
      bus_write(A_DATA, 64'h999);
      read_expect("R9 overflow set", A_STAT, 64'h5);
      bus_write(A_STAT, 64'h0);
      read_expect("R9 write zero keeps flag", A_STAT, 64'h5);
      bus_write(A_STAT, 64'h1);
      read_expect("R9 write one clears flag", A_STAT, 64'h4);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R5 tx order", {31'b0, txv1, txd1}, {31'b0, 1'b1, 32'h0000_0100 + 32'(i)});
         tx_pop = 1'b1;
         @(negedge clk);
         tx_pop = 1'b0;
      end
      chk("R9 dropped word absent", {63'b0, txv0}, 64'd0);

      // R11 receive overflow
      for (int i = 0; i < 5; i++) rx_put(32'h700 + 32'(i));
      chk("R11 rx_full", {62'b0, rxf1, rxf0}, 64'd3);
      for (int i = 0; i < 4; i++)
         read_expect("R11 kept words", A_DATA, 64'h700 + 64'(i));
      read_expect("R11 fifth word dropped", A_STAT, 64'h0);

      // R12 reset mid-run
      bus_write(A_CTRL, 64'hAB);
      rx_put(32'h1234);
      bus_write(A_DATA, 64'h5678);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R12 ctrl cleared", ctrl0 | ctrl1, 64'd0);
      chk("R12 tx cleared", {62'b0, txv1, txv0}, 64'd0);
      read_expect("R12 status cleared", A_STAT, 64'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule